// File: doc/BRIEF.md
# Type 0 Configuration Header Register File

This block is the configuration header of one function, held as a register file. A host-side agent reaches it through a dword-aligned 12-bit byte offset. Only bits 11:2 of the offset are brought in, so an access always covers a full 32-bit dword. Reads are registered and return one cycle after the request. Writes take effect at the clock edge that samples them.

The header holds fixed identity and class fields set by parameters, plus a 16-bit command word and two writable bytes: cache line size and interrupt line. It also holds six base address slots. Parameters describe each slot: whether it exists, whether it decodes I/O or 32-bit memory space, and log2 of its size.

A write to a memory slot is trimmed to the slot's natural alignment. Writing all ones and reading back therefore returns the size mask. An I/O slot keeps bits 31:2 of the written value and always reads with bit 0 set. After every write to an existing slot, the block emits a single-cycle notice carrying the slot number and the aligned base. An address decoder further down the chip can use this notice to move its window.

Top module: `cfgspace_type0`

## Requirements
- R1: During and after reset, before any write: command, cache line size and interrupt line are zero; every existing memory slot reads zero; every existing I/O slot reads 0x00000001; `cfg_rvalid` and `bar_upd_valid` are low.
- R2: A read request in one cycle makes `cfg_rvalid` high in the next cycle with the dword selected by `cfg_addr`. `cfg_rvalid` is low in every cycle that does not follow a read request.
- R3: The following dwords are read-only and ignore writes:
  - dword 0x00 reads {device ID, vendor ID};
  - dword 0x08 reads {class, subclass, programming interface, revision} from bit 31 down;
  - dword 0x2C reads {subsystem ID, subsystem vendor ID}.
- R4: Dword 0x04 bits 15:0 are the writable command word. Bits 31:16 are a read-only status value.
- R5: Dword 0x0C bits 7:0 are the writable cache line size. Bits 15:8 (latency timer), 23:16 (header type) and 31:24 (self-test) are read-only.
- R6: Dword 0x3C bits 7:0 are the writable interrupt line. Bits 15:8 (interrupt pin), 23:16 (minimum grant) and 31:24 (maximum latency) are read-only.
- R7: A write of W to an existing memory slot stores W with bits 3:0 cleared and with every bit below log2(size) cleared.
- R8: A write of W to an existing I/O slot stores W with bits 1:0 cleared. The slot reads back that value with bit 0 set to 1.
- R9: A slot that does not exist reads zero, ignores writes and produces no notice. Slot n sits at dword 0x10 + 4n, for n = 0 to 5.
- R10: One cycle after a write to an existing slot n, `bar_upd_valid` is high for that cycle, with `bar_upd_idx` = n. `bar_upd_base` equals the stored value with bit 0 clear. `bar_upd_valid` is low in every other cycle.
- R11: The following read zero and ignore writes:
  - dwords 0x28, 0x30 and 0x38;
  - bits 31:8 of dword 0x34, whose bits 7:0 hold the read-only capability pointer;
  - every offset from 0x40 to 0xFFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write request for the addressed dword |
| cfg_rd | input | 1 | Read request for the addressed dword |
| cfg_addr | input | 10 | Byte offset bits 11:2 (dword index) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with `cfg_rvalid` |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_rd` |
| bar_upd_valid | output | 1 | Single-cycle notice of a slot write |
| bar_upd_idx | output | 3 | Slot number of the notice |
| bar_upd_base | output | 32 | Aligned base of the notice |

## Verification
Some properties are checked on every cycle:
- the read handshake timing;
- the identity dword's contents;
- the zero read-back of everything beyond the header;
- the forced low bits of I/O slot reads;
- the cause and alignment of each notice.

Other behaviour can only be shown by the bench's scenarios:
- the exact alignment arithmetic per slot size;
- which bytes of a mixed dword are writable;
- that unused slots stay silent.

The bench covers these by sweeping every dword of the 4 KB space with several write patterns and comparing each read against a model built from the requirements.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;
  localparam int CFG_ADDR_W   = 12;
  localparam int CFG_DW_W     = CFG_ADDR_W - 2;
  localparam int CFG_DATA_W   = 32;
  localparam int CFG_NUM_BARS = 6;
  localparam int CFG_IDX_W    = 3;
  localparam int CFG_LOG2_W   = 5;

  localparam logic [CFG_DW_W-1:0] DW_IDENT   = CFG_DW_W'(0);
  localparam logic [CFG_DW_W-1:0] DW_CMDSTAT = CFG_DW_W'(1);
  localparam logic [CFG_DW_W-1:0] DW_CLASS   = CFG_DW_W'(2);
  localparam logic [CFG_DW_W-1:0] DW_MISC    = CFG_DW_W'(3);
  localparam logic [CFG_DW_W-1:0] DW_BAR0    = CFG_DW_W'(4);
  localparam logic [CFG_DW_W-1:0] DW_SUBSYS  = CFG_DW_W'(11);
  localparam logic [CFG_DW_W-1:0] DW_CAP     = CFG_DW_W'(13);
  localparam logic [CFG_DW_W-1:0] DW_INTR    = CFG_DW_W'(15);

  // Bits a memory slot keeps: above the size and above bit 3.
  function automatic logic [CFG_DATA_W-1:0] mem_keep_mask(input logic [CFG_LOG2_W-1:0] lg);
    logic [CFG_DATA_W-1:0] m;
    m = {CFG_DATA_W{1'b1}} << lg;
    return m & ~CFG_DATA_W'(32'hF);
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfgspace_pkg::*;
#(
  parameter bit                  IMPL      = 1'b1,
  parameter bit                  IS_IO     = 1'b0,
  parameter logic [CFG_LOG2_W-1:0] SIZE_LOG2 = CFG_LOG2_W'(12)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hit,
  input  logic [CFG_DATA_W-1:0] wdata,
  output logic [CFG_DATA_W-1:0] rd_val,
  output logic [CFG_DATA_W-1:0] new_base
);
  logic [CFG_DATA_W-1:0] keep_mask;
  logic [CFG_DATA_W-1:0] rd_flag;
  logic [CFG_DATA_W-1:0] base_q, base_d;
  logic                  base_en;

  generate
    if (IS_IO) begin : g_io
      assign keep_mask = ~CFG_DATA_W'(32'h3);
      assign rd_flag   = CFG_DATA_W'(32'h1);
    end else begin : g_mem
      assign keep_mask = mem_keep_mask(SIZE_LOG2);
      assign rd_flag   = '0;
    end
  endgenerate

  assign new_base = IMPL ? (wdata & keep_mask) : '0;
  assign base_en  = wr_hit & IMPL;

  always_comb begin
    base_d = base_q;
    if (base_en) base_d = new_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign rd_val = IMPL ? (base_q | rd_flag) : '0;
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfgspace_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h0,
  parameter logic [15:0] DEVICE_ID  = 16'h0,
  parameter logic [7:0]  REVISION   = 8'h0,
  parameter logic [7:0]  PROG_IF    = 8'h0,
  parameter logic [7:0]  SUBCLASS   = 8'h0,
  parameter logic [7:0]  CLASS_CODE = 8'h0,
  parameter logic [15:0] STATUS_VAL = 16'h0,
  parameter logic [7:0]  LAT_TIMER  = 8'h0,
  parameter logic [7:0]  HDR_TYPE   = 8'h0,
  parameter logic [7:0]  SELFTEST   = 8'h0,
  parameter logic [15:0] SUBSYS_VID = 16'h0,
  parameter logic [15:0] SUBSYS_ID  = 16'h0,
  parameter logic [7:0]  CAP_PTR    = 8'h0,
  parameter logic [7:0]  INT_PIN    = 8'h0,
  parameter logic [7:0]  MIN_GNT    = 8'h0,
  parameter logic [7:0]  MAX_LAT    = 8'h0
) (
  input  logic [CFG_DW_W-1:0]                dw,
  input  logic [15:0]                        cmd,
  input  logic [7:0]                         cls,
  input  logic [7:0]                         intl,
  input  logic [CFG_NUM_BARS*CFG_DATA_W-1:0] bar_rd,
  output logic [CFG_DATA_W-1:0]              rdata
);
  always_comb begin
    rdata = '0;
    unique case (dw)
      DW_IDENT:   rdata = {DEVICE_ID, VENDOR_ID};
      DW_CMDSTAT: rdata = {STATUS_VAL, cmd};
      DW_CLASS:   rdata = {CLASS_CODE, SUBCLASS, PROG_IF, REVISION};
      DW_MISC:    rdata = {SELFTEST, HDR_TYPE, LAT_TIMER, cls};
      DW_SUBSYS:  rdata = {SUBSYS_ID, SUBSYS_VID};
      DW_CAP:     rdata = {24'h0, CAP_PTR};
      DW_INTR:    rdata = {MAX_LAT, MIN_GNT, INT_PIN, intl};
      default:    rdata = '0;
    endcase
    for (int i = 0; i < CFG_NUM_BARS; i++) begin
      if (dw == DW_BAR0 + CFG_DW_W'(i)) rdata = bar_rd[i*CFG_DATA_W +: CFG_DATA_W];
    end
  end
endmodule

// File: rtl/cfgspace_type0.sv
module cfgspace_type0
  import cfgspace_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID  = 16'hA5C3,
  parameter logic [7:0]  REVISION   = 8'h02,
  parameter logic [7:0]  PROG_IF    = 8'h01,
  parameter logic [7:0]  SUBCLASS   = 8'h06,
  parameter logic [7:0]  CLASS_CODE = 8'h0C,
  parameter logic [15:0] STATUS_VAL = 16'h0010,
  parameter logic [7:0]  LAT_TIMER  = 8'h20,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  SELFTEST   = 8'h00,
  parameter logic [15:0] SUBSYS_VID = 16'h1AB4,
  parameter logic [15:0] SUBSYS_ID  = 16'h0042,
  parameter logic [7:0]  CAP_PTR    = 8'h50,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h03,
  parameter logic [7:0]  MAX_LAT    = 8'h08,
  parameter logic [CFG_NUM_BARS-1:0]            BAR_IMPL      = 6'b010111,
  parameter logic [CFG_NUM_BARS-1:0]            BAR_IS_IO     = 6'b000010,
  parameter logic [CFG_NUM_BARS*CFG_LOG2_W-1:0] BAR_SIZE_LOG2 =
    {5'd0, 5'd4, 5'd0, 5'd20, 5'd3, 5'd12}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic                  cfg_rd,
  input  logic [CFG_ADDR_W-1:2] cfg_addr,
  input  logic [CFG_DATA_W-1:0] cfg_wdata,
  output logic [CFG_DATA_W-1:0] cfg_rdata,
  output logic                  cfg_rvalid,
  output logic                  bar_upd_valid,
  output logic [CFG_IDX_W-1:0]  bar_upd_idx,
  output logic [CFG_DATA_W-1:0] bar_upd_base
);
  logic rst_i_n;

  cfg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // Write decode
  logic wr_cmd, wr_cls, wr_intl;
  logic [CFG_NUM_BARS-1:0] bar_hit;

  assign wr_cmd  = cfg_wr && (cfg_addr == DW_CMDSTAT);
  assign wr_cls  = cfg_wr && (cfg_addr == DW_MISC);
  assign wr_intl = cfg_wr && (cfg_addr == DW_INTR);

  // Base address slots
  logic [CFG_NUM_BARS*CFG_DATA_W-1:0] bar_rd;
  logic [CFG_DATA_W-1:0]              bar_new [CFG_NUM_BARS];

  generate
    for (genvar i = 0; i < CFG_NUM_BARS; i++) begin : g_bar
      assign bar_hit[i] = cfg_wr && (cfg_addr == DW_BAR0 + CFG_DW_W'(i));
      cfg_bar_slot #(
        .IMPL      (BAR_IMPL[i]),
        .IS_IO     (BAR_IS_IO[i]),
        .SIZE_LOG2 (BAR_SIZE_LOG2[i*CFG_LOG2_W +: CFG_LOG2_W])
      ) u_slot (
        .clk      (clk),
        .rst_n    (rst_i_n),
        .wr_hit   (bar_hit[i]),
        .wdata    (cfg_wdata),
        .rd_val   (bar_rd[i*CFG_DATA_W +: CFG_DATA_W]),
        .new_base (bar_new[i])
      );
    end
  endgenerate

  // Writable scalar fields
  logic [15:0] cmd_q, cmd_d;
  logic [7:0]  cls_q, cls_d;
  logic [7:0]  intl_q, intl_d;

  always_comb begin
    cmd_d  = cmd_q;
    cls_d  = cls_q;
    intl_d = intl_q;
    if (wr_cmd)  cmd_d  = cfg_wdata[15:0];
    if (wr_cls)  cls_d  = cfg_wdata[7:0];
    if (wr_intl) intl_d = cfg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_q  <= '0;
      cls_q  <= '0;
      intl_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      cls_q  <= cls_d;
      intl_q <= intl_d;
    end
  end

  // Read path
  logic [CFG_DATA_W-1:0] mux_out;

  cfg_rd_mux #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .PROG_IF(PROG_IF), .SUBCLASS(SUBCLASS), .CLASS_CODE(CLASS_CODE),
    .STATUS_VAL(STATUS_VAL), .LAT_TIMER(LAT_TIMER), .HDR_TYPE(HDR_TYPE),
    .SELFTEST(SELFTEST), .SUBSYS_VID(SUBSYS_VID), .SUBSYS_ID(SUBSYS_ID),
    .CAP_PTR(CAP_PTR), .INT_PIN(INT_PIN), .MIN_GNT(MIN_GNT), .MAX_LAT(MAX_LAT)
  ) u_mux (
    .dw     (cfg_addr),
    .cmd    (cmd_q),
    .cls    (cls_q),
    .intl   (intl_q),
    .bar_rd (bar_rd),
    .rdata  (mux_out)
  );

  logic [CFG_DATA_W-1:0] rdata_q, rdata_d;
  logic                  rvalid_q;

  always_comb begin
    rdata_d = rdata_q;
    if (cfg_rd) rdata_d = mux_out;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= cfg_rd;
    end
  end

  // Slot change notice
  logic                  upd_v_q, upd_v_d;
  logic [CFG_IDX_W-1:0]  upd_i_q, upd_i_d;
  logic [CFG_DATA_W-1:0] upd_b_q, upd_b_d;

  always_comb begin
    upd_v_d = 1'b0;
    upd_i_d = upd_i_q;
    upd_b_d = upd_b_q;
    for (int i = 0; i < CFG_NUM_BARS; i++) begin
      if (bar_hit[i] && BAR_IMPL[i]) begin
        upd_v_d = 1'b1;
        upd_i_d = CFG_IDX_W'(i);
        upd_b_d = bar_new[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      upd_v_q <= 1'b0;
      upd_i_q <= '0;
      upd_b_q <= '0;
    end else begin
      upd_v_q <= upd_v_d;
      upd_i_q <= upd_i_d;
      upd_b_q <= upd_b_d;
    end
  end

  assign cfg_rdata     = rdata_q;
  assign cfg_rvalid    = rvalid_q;
  assign bar_upd_valid = upd_v_q;
  assign bar_upd_idx   = upd_i_q;
  assign bar_upd_base  = upd_b_q;
endmodule

// File: rtl/cfgspace_type0_chk.sv
module cfgspace_type0_chk
  import cfgspace_pkg::*;
#(
  parameter logic [15:0]             VENDOR_ID = 16'h0,
  parameter logic [15:0]             DEVICE_ID = 16'h0,
  parameter logic [CFG_NUM_BARS-1:0] BAR_IMPL  = '0,
  parameter logic [CFG_NUM_BARS-1:0] BAR_IS_IO = '0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_rd,
  input logic                  cfg_wr,
  input logic [CFG_ADDR_W-1:2] cfg_addr,
  input logic [CFG_DATA_W-1:0] cfg_rdata,
  input logic                  cfg_rvalid,
  input logic                  bar_upd_valid,
  input logic [CFG_IDX_W-1:0]  bar_upd_idx,
  input logic [CFG_DATA_W-1:0] bar_upd_base
);
  logic [CFG_DW_W-1:0] last_dw;
  logic [CFG_DW_W-1:0] rel;
  logic                last_io;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_dw <= '0;
    else if (cfg_rd) last_dw <= cfg_addr;
  end

  assign rel     = last_dw - DW_BAR0;
  assign last_io = (last_dw >= DW_BAR0) && (rel < CFG_DW_W'(CFG_NUM_BARS)) &&
                   BAR_IMPL[rel[CFG_IDX_W-1:0]] && BAR_IS_IO[rel[CFG_IDX_W-1:0]];

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid);
  assert_rvalid_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid |-> $past(cfg_rd));
  assert_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && last_dw == DW_IDENT) |-> cfg_rdata == {DEVICE_ID, VENDOR_ID});
  assert_beyond_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && last_dw >= CFG_DW_W'(16)) |-> cfg_rdata == '0);
  assert_io_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && last_io) |-> cfg_rdata[1:0] == 2'b01);
  assert_upd_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bar_upd_valid |-> ($past(cfg_wr) && ((BAR_IMPL >> bar_upd_idx) & 1) == 1));
  assert_upd_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_upd_valid && ((BAR_IS_IO >> bar_upd_idx) & 1) == 0) |-> bar_upd_base[3:0] == 4'h0);
  assert_upd_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bar_upd_valid |-> bar_upd_base[1:0] == 2'b00);
endmodule

bind cfgspace_type0 cfgspace_type0_chk #(
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
  .BAR_IMPL(BAR_IMPL), .BAR_IS_IO(BAR_IS_IO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
  .bar_upd_valid(bar_upd_valid), .bar_upd_idx(bar_upd_idx),
  .bar_upd_base(bar_upd_base)
);

// File: tb/sim_cfgspace_type0.sv
`timescale 1ns/1ps
module sim_cfgspace_type0;
  localparam real CLK_NS = 4.0;

  localparam logic [15:0] P_VEN  = 16'h1D0F;
  localparam logic [15:0] P_DEV  = 16'hA5C3;
  localparam logic [7:0]  P_REV  = 8'h02;
  localparam logic [7:0]  P_PIF  = 8'h01;
  localparam logic [7:0]  P_SUB  = 8'h06;
  localparam logic [7:0]  P_CLS  = 8'h0C;
  localparam logic [15:0] P_STAT = 16'h0010;
  localparam logic [7:0]  P_LAT  = 8'h20;
  localparam logic [7:0]  P_HDR  = 8'h00;
  localparam logic [7:0]  P_BIST = 8'h00;
  localparam logic [15:0] P_SVID = 16'h1AB4;
  localparam logic [15:0] P_SID  = 16'h0042;
  localparam logic [7:0]  P_CAP  = 8'h50;
  localparam logic [7:0]  P_IPIN = 8'h01;
  localparam logic [7:0]  P_MING = 8'h03;
  localparam logic [7:0]  P_MAXL = 8'h08;
  localparam logic [5:0]  P_IMPL = 6'b010111;
  localparam logic [5:0]  P_IO   = 6'b000010;
  localparam logic [29:0] P_LG   = {5'd0, 5'd4, 5'd0, 5'd20, 5'd3, 5'd12};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [11:2] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, bar_upd_base;
  logic        cfg_rvalid, bar_upd_valid;
  logic [2:0]  bar_upd_idx;

  always #(CLK_NS/2) clk = ~clk;

  cfgspace_type0 #(
    .VENDOR_ID(P_VEN), .DEVICE_ID(P_DEV), .REVISION(P_REV), .PROG_IF(P_PIF),
    .SUBCLASS(P_SUB), .CLASS_CODE(P_CLS), .STATUS_VAL(P_STAT), .LAT_TIMER(P_LAT),
    .HDR_TYPE(P_HDR), .SELFTEST(P_BIST), .SUBSYS_VID(P_SVID), .SUBSYS_ID(P_SID),
    .CAP_PTR(P_CAP), .INT_PIN(P_IPIN), .MIN_GNT(P_MING), .MAX_LAT(P_MAXL),
    .BAR_IMPL(P_IMPL), .BAR_IS_IO(P_IO), .BAR_SIZE_LOG2(P_LG)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .bar_upd_valid(bar_upd_valid),
    .bar_upd_idx(bar_upd_idx), .bar_upd_base(bar_upd_base)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Model state
  logic [15:0] m_cmd;
  logic [7:0]  m_cls, m_intl;
  logic [31:0] m_bar [6];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  function automatic int slot_of(input int d);
    return (d >= 4 && d <= 9) ? d - 4 : -1;
  endfunction

  function automatic string req_of(input int d);
    int s;
    s = slot_of(d);
    if (s >= 0) return !P_IMPL[s] ? "R9" : (P_IO[s] ? "R8" : "R7");
    case (d)
      0, 2, 11: return "R3";
      1:        return "R4";
      3:        return "R5";
      15:       return "R6";
      default:  return "R11";
    endcase
  endfunction

  function automatic logic [31:0] exp_dw(input int d);
    int s;
    s = slot_of(d);
    if (s >= 0) return !P_IMPL[s] ? 32'h0 : (m_bar[s] | (P_IO[s] ? 32'h1 : 32'h0));
    case (d)
      0:  return {P_DEV, P_VEN};
      1:  return {P_STAT, m_cmd};
      2:  return {P_CLS, P_SUB, P_PIF, P_REV};
      3:  return {P_BIST, P_HDR, P_LAT, m_cls};
      11: return {P_SID, P_SVID};
      13: return {24'h0, P_CAP};
      15: return {P_MAXL, P_MING, P_IPIN, m_intl};
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd_chk(input int d, input string req);
    @(negedge clk);
    cfg_rd   = 1'b1;
    cfg_addr = 10'(d);
    @(negedge clk);
    cfg_rd = 1'b0;
    chk("R2", {31'h0, cfg_rvalid}, 32'h1);
    chk(req, cfg_rdata, exp_dw(d));
  endtask

  task automatic wr_chk(input int d, input logic [31:0] w);
    int s;
    int lg;
    logic [31:0] stored;
    s = slot_of(d);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_addr  = 10'(d);
    cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    // model update
    case (d)
      1:  m_cmd  = w[15:0];
      3:  m_cls  = w[7:0];
      15: m_intl = w[7:0];
      default: ;
    endcase
    if (s >= 0 && P_IMPL[s]) begin
      lg = int'(P_LG[s*5 +: 5]);
      if (P_IO[s]) stored = w - (w % 32'd4);
      else begin
        stored = w - (w % 32'd16);
        stored = stored - (stored % (32'd1 << lg));
      end
      m_bar[s] = stored;
      chk("R10", {31'h0, bar_upd_valid}, 32'h1);
      chk("R10", {29'h0, bar_upd_idx}, 32'(s));
      chk("R10", bar_upd_base, stored);
    end else begin
      chk(s >= 0 ? "R9" : "R10", {31'h0, bar_upd_valid}, 32'h0);
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5A5_5A5A;
    pats[3] = 32'h1234_5678;
    pats[4] = 32'h0F0F_F0F3;
    m_cmd = '0; m_cls = '0; m_intl = '0;
    for (int i = 0; i < 6; i++) m_bar[i] = '0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    chk("R1", {31'h0, cfg_rvalid}, 32'h0);
    chk("R1", {31'h0, bar_upd_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {31'h0, bar_upd_valid}, 32'h0);
    // Reset contents of the header, then idle rvalid after a read
    for (int d = 0; d < 16; d++) rd_chk(d, "R1");
    @(negedge clk);
    chk("R2", {31'h0, cfg_rvalid}, 32'h0);
    // Exhaustive sweep of all dwords with several patterns
    for (int p = 0; p < 5; p++) begin
      for (int d = 0; d < 1024; d++) begin
        wr_chk(d, pats[p]);
        rd_chk(d, req_of(d));
      end
    end
    // Header re-read after the sweep: identity untouched, last writes held
    for (int d = 0; d < 16; d++) rd_chk(d, req_of(d));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule